// File: doc/BRIEF.md
# Debug address compare event unit

This unit watches the address streams of a simple processor core and raises debug events when an access hits a programmed address. It has two instruction comparators, which watch the fetch address, and two data comparators, which watch the load/store address. A control word selects how the instruction pair is used:

- two independent exact matches;
- one masked bit match;
- an inclusive range;
- an exclusive range.

The control word also gives every comparator a privilege qualifier and an address-space qualifier.

Each comparator drives an event pulse. The pulse is combinational and appears in the same cycle as the qualifying access. Each event also sets a sticky status bit, which software clears by writing ones.

The two monitored access streams are observe-only. Each carries a valid strobe and no ready: the unit never applies back-pressure, and every access presented with its strobe high is evaluated in that cycle. The configuration port is a plain single-cycle write strobe gated by a supervisor qualifier, and it has a combinational read-back mux.

Register addresses (`cfg_addr` / `cfg_raddr`) are:

| Address | Register |
|---|---|
| 0 | control |
| 1 | instruction compare 1 |
| 2 | instruction compare 2 |
| 3 | data compare 1 |
| 4 | data compare 2 |
| 5 | status |

Addresses 6 and 7 read zero.

Event and status bit order is:

| Bit | Source |
|---|---|
| 0 | instruction comparator 1 |
| 1 | instruction comparator 2 |
| 2 | data comparator 1 |
| 3 | data comparator 2 |

Top module: `dbg_addr_watch`

## Requirements
- R1: After reset, every register reads zero, `ev_o` is 0 and `sticky_o` is 0.
- R2: With control[1:0]=00, bit 0 fires when the fetch address equals instruction compare 1, and bit 1 fires independently when it equals instruction compare 2.
- R3: With control[1:0]=01, bits 0 and 1 fire when (fetch address AND compare 2) equals (compare 1 AND compare 2).
- R4: With control[1:0]=10, bits 0 and 1 fire when compare 1 <= fetch address < compare 2, using unsigned comparison.
- R5: With control[1:0]=11, bits 0 and 1 fire when the fetch address < compare 1 or >= compare 2, using unsigned comparison.
- R6: In modes 01, 10 and 11, bits 0 and 1 are always equal. A paired hit fires only when the qualifiers of both instruction comparators pass.
- R7: Each comparator has a privilege qualifier in bits [1:0] of its nibble. Nibble k occupies control[4k+5:4k+2]. The encodings are:
  - 00: always eligible;
  - 10: eligible only when `priv_user`=0;
  - 11: eligible only when `priv_user`=1.
- R8: Each comparator has a space qualifier in bits [3:2] of its nibble. Instruction comparators test `ispace`; data comparators test `dspace`. The encodings are:
  - 00: no restriction;
  - 10: eligible only when the tested bit is 0;
  - 11: eligible only when the tested bit is 1.
- R9: A qualifier field holding the reserved code 01 suppresses every event of its comparator.
- R10: An event is output only in a cycle where the matching valid strobe (`if_valid` or `ds_valid`) is high. It is combinational in that cycle.
- R11: Each event sets its `sticky_o` bit at the next clock edge. Writing status with a 1 clears that bit. If a set and a clear coincide, the set wins.
- R12: Writes take effect only when `cfg_sup`=1. Control bits [31:18] always read zero.
- R13: A data comparator fires when `ds_addr` equals its compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sup | input | 1 | Supervisor access; writes are ignored when low |
| cfg_addr | input | 3 | Write register address |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 3 | Read register address |
| cfg_rdata | output | 32 | Read data (combinational) |
| if_valid | input | 1 | Fetch access valid |
| if_addr | input | 32 | Fetch address |
| ds_valid | input | 1 | Load/store access valid |
| ds_addr | input | 32 | Load/store address |
| priv_user | input | 1 | Core privilege bit (1 = user) |
| ispace | input | 1 | Instruction-space translation bit |
| dspace | input | 1 | Data-space translation bit |
| ev_o | output | 4 | Event pulses, one per comparator |
| sticky_o | output | 4 | Sticky event status |

## Verification
Event outputs are due in the same cycle as the access that causes them. The bench drives each access just after a rising edge and compares `ev_o` at the following falling edge, against a model evaluated on the same inputs and the register contents of that cycle. Sticky bits and register writes land on the next rising edge, so the model commits its next state on that edge and the change is checked at the following falling edge. Read-back is combinational, and the bench sweeps `cfg_raddr` every cycle so that every register is compared continuously.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
  localparam int CTRL_W    = 32;
  localparam int CTRL_USED = 18;
  localparam int NCMP      = 4;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_IA1  = 3'd1;
  localparam logic [2:0] RA_IA2  = 3'd2;
  localparam logic [2:0] RA_DA1  = 3'd3;
  localparam logic [2:0] RA_DA2  = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;

  typedef enum logic [1:0] {
    PAIR_EXACT     = 2'b00,
    PAIR_MASK      = 2'b01,
    PAIR_RANGE_IN  = 2'b10,
    PAIR_RANGE_OUT = 2'b11
  } pair_mode_e;

  typedef enum logic [1:0] {
    QL_ANY  = 2'b00,
    QL_RSV  = 2'b01,
    QL_ZERO = 2'b10,
    QL_ONE  = 2'b11
  } qual_code_e;

  typedef struct packed {
    qual_code_e space;
    qual_code_e priv;
  } qual_t;

  typedef struct packed {
    logic [CTRL_W-CTRL_USED-1:0] rsvd;
    qual_t [NCMP-1:0]            qual;
    pair_mode_e                  mode;
  } ctrl_t;
endpackage

// File: rtl/dbgw_qual.sv
module dbgw_qual
  import dbgw_pkg::*;
(
  input  qual_t q,
  input  logic  pr,
  input  logic  sp,
  output logic  ok
);
  logic pr_ok, sp_ok;

  always_comb begin
    case (q.priv)
      QL_ANY:  pr_ok = 1'b1;
      QL_ZERO: pr_ok = !pr;
      QL_ONE:  pr_ok = pr;
      default: pr_ok = 1'b0;
    endcase
    case (q.space)
      QL_ANY:  sp_ok = 1'b1;
      QL_ZERO: sp_ok = !sp;
      QL_ONE:  sp_ok = sp;
      default: sp_ok = 1'b0;
    endcase
    ok = pr_ok && sp_ok;
  end
endmodule

// File: rtl/dbgw_icmp.sv
module dbgw_icmp
  import dbgw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pair_mode_e    mode,
  input  logic [AW-1:0] r1,
  input  logic [AW-1:0] r2,
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    ok,
  output logic [1:0]    ev
);
  logic eq1, eq2, ge1, lt2, mhit, pair_hit;

  always_comb begin
    eq1  = (addr == r1);
    eq2  = (addr == r2);
    ge1  = (addr >= r1);
    lt2  = (addr <  r2);
    mhit = ((addr & r2) == (r1 & r2));
    case (mode)
      PAIR_MASK:      pair_hit = mhit;
      PAIR_RANGE_IN:  pair_hit = ge1 && lt2;
      PAIR_RANGE_OUT: pair_hit = !ge1 || !lt2;
      default:        pair_hit = 1'b0;
    endcase
    if (mode == PAIR_EXACT) begin
      ev[0] = valid && eq1 && ok[0];
      ev[1] = valid && eq2 && ok[1];
    end else begin
      ev[0] = valid && pair_hit && ok[0] && ok[1];
      ev[1] = ev[0];
    end
  end

  AST_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PAIR_EXACT) |-> (ev[0] == ev[1])); // R6
  AST_IEV_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |-> valid); // R10
  AST_RANGE_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PAIR_RANGE_IN && ev[0]) |-> (addr >= r1 && addr < r2)); // R4
endmodule

// File: rtl/dbgw_regs.sv
module dbgw_regs
  import dbgw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            sup,
  input  logic [2:0]      waddr,
  input  logic [AW-1:0]   wdata,
  input  logic [2:0]      raddr,
  input  logic [NCMP-1:0] sticky,
  output ctrl_t           ctrl,
  output logic [AW-1:0]   ia1,
  output logic [AW-1:0]   ia2,
  output logic [AW-1:0]   da1,
  output logic [AW-1:0]   da2,
  output logic [NCMP-1:0] clr,
  output logic [AW-1:0]   rdata
);
  localparam int RSV_W = CTRL_W - CTRL_USED;

  logic [CTRL_USED-1:0] ctrl_q;
  logic                 wr_ok;

  assign wr_ok = wr_en && sup;
  assign ctrl  = ctrl_t'({{RSV_W{1'b0}}, ctrl_q});
  assign clr   = (wr_ok && waddr == RA_STAT) ? wdata[NCMP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ia1    <= '0;
      ia2    <= '0;
      da1    <= '0;
      da2    <= '0;
    end else if (wr_ok) begin
      case (waddr)
        RA_CTRL: ctrl_q <= wdata[CTRL_USED-1:0];
        RA_IA1:  ia1    <= wdata;
        RA_IA2:  ia2    <= wdata;
        RA_DA1:  da1    <= wdata;
        RA_DA2:  da2    <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (raddr)
      RA_CTRL: rdata = AW'(ctrl);
      RA_IA1:  rdata = ia1;
      RA_IA2:  rdata = ia2;
      RA_DA1:  rdata = da1;
      RA_DA2:  rdata = da2;
      RA_STAT: rdata = AW'(sticky);
      default: rdata = '0;
    endcase
  end

  AST_USER_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sup) |=> ($stable(ctrl_q) && $stable(ia1) && $stable(ia2)
                         && $stable(da1) && $stable(da2))); // R12
endmodule

// File: rtl/dbgw_status.sv
module dbgw_status
  import dbgw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMP-1:0] ev,
  input  logic [NCMP-1:0] clr,
  output logic [NCMP-1:0] sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~clr) | ev;
  end

  generate
    for (genvar k = 0; k < NCMP; k++) begin : g_chk
      AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev[k] |=> sticky[k]); // R11
      AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[k] && !ev[k]) |=> !sticky[k]); // R11
    end
  endgenerate
endmodule

// File: rtl/dbg_addr_watch.sv
module dbg_addr_watch
  import dbgw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr_en,
  input  logic            cfg_sup,
  input  logic [2:0]      cfg_addr,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic [2:0]      cfg_raddr,
  output logic [AW-1:0]   cfg_rdata,
  input  logic            if_valid,
  input  logic [AW-1:0]   if_addr,
  input  logic            ds_valid,
  input  logic [AW-1:0]   ds_addr,
  input  logic            priv_user,
  input  logic            ispace,
  input  logic            dspace,
  output logic [NCMP-1:0] ev_o,
  output logic [NCMP-1:0] sticky_o
);
  ctrl_t           ctrl;
  logic [AW-1:0]   ia1, ia2;
  logic [AW-1:0]   dreg [2];
  logic [NCMP-1:0] clr, qok;

  dbgw_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .sup(cfg_sup),
    .waddr(cfg_addr), .wdata(cfg_wdata), .raddr(cfg_raddr),
    .sticky(sticky_o), .ctrl(ctrl), .ia1(ia1), .ia2(ia2),
    .da1(dreg[0]), .da2(dreg[1]), .clr(clr), .rdata(cfg_rdata)
  );

  generate
    for (genvar k = 0; k < NCMP; k++) begin : g_qual
      dbgw_qual u_q (
        .q(ctrl.qual[k]), .pr(priv_user),
        .sp((k < 2) ? ispace : dspace), .ok(qok[k])
      );
      AST_RSV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.qual[k].priv == QL_RSV || ctrl.qual[k].space == QL_RSV)
          |-> !ev_o[k]); // R9
    end
  endgenerate

  dbgw_icmp #(.AW(AW)) u_icmp (
    .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .r1(ia1), .r2(ia2),
    .valid(if_valid), .addr(if_addr), .ok(qok[1:0]), .ev(ev_o[1:0])
  );

  generate
    for (genvar k = 0; k < 2; k++) begin : g_dcmp
      assign ev_o[2+k] = ds_valid && (ds_addr == dreg[k]) && qok[2+k];
      AST_DEV_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[2+k] |-> ds_valid); // R10
    end
  endgenerate

  dbgw_status u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev_o), .clr(clr), .sticky(sticky_o)
  );

  AST_PRIV_SUP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o[2] && ctrl.qual[2].priv == QL_ZERO) |-> !priv_user); // R7
  AST_SPACE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o[0] && ctrl.qual[0].space == QL_ONE) |-> ispace); // R8
endmodule

// File: tb/dbg_addr_watch_tb_top.sv
module dbg_addr_watch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_sup = 1'b0;
  logic [2:0]  cfg_addr = '0, cfg_raddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        if_valid = 1'b0, ds_valid = 1'b0;
  logic [31:0] if_addr = '0, ds_addr = '0;
  logic        priv_user = 1'b0, ispace = 1'b0, dspace = 1'b0;
  logic [3:0]  ev_o, sticky_o;

  int    vecs = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  logic [31:0] m_ctrl = '0, m_ia1 = '0, m_ia2 = '0, m_da1 = '0, m_da2 = '0;
  logic [3:0]  m_st = '0;
  logic [31:0] n_ctrl = '0, n_ia1 = '0, n_ia2 = '0, n_da1 = '0, n_da2 = '0;
  logic [3:0]  n_st = '0;

  always #4 clk = ~clk;

  dbg_addr_watch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sup(cfg_sup),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata), .if_valid(if_valid), .if_addr(if_addr),
    .ds_valid(ds_valid), .ds_addr(ds_addr), .priv_user(priv_user),
    .ispace(ispace), .dspace(dspace), .ev_o(ev_o), .sticky_o(sticky_o)
  );

  function automatic bit code_ok(input logic [1:0] c, input logic b);
    if (c == 2'b00) return 1'b1;
    if (c == 2'b10) return !b;
    if (c == 2'b11) return b;
    return 1'b0;
  endfunction

  function automatic bit nib_ok(input logic [3:0] n, input logic p, input logic s);
    return code_ok(n[1:0], p) && code_ok(n[3:2], s);
  endfunction

  function automatic logic [3:0] exp_ev();
    logic [3:0] e;
    bit ok0, ok1, ok2, ok3, hit;
    ok0 = nib_ok(m_ctrl[5:2],   priv_user, ispace);
    ok1 = nib_ok(m_ctrl[9:6],   priv_user, ispace);
    ok2 = nib_ok(m_ctrl[13:10], priv_user, dspace);
    ok3 = nib_ok(m_ctrl[17:14], priv_user, dspace);
    e = '0;
    if (m_ctrl[1:0] == 2'b00) begin
      e[0] = if_valid && if_addr == m_ia1 && ok0;
      e[1] = if_valid && if_addr == m_ia2 && ok1;
    end else begin
      if (m_ctrl[1:0] == 2'b01)      hit = ((if_addr & m_ia2) == (m_ia1 & m_ia2));
      else if (m_ctrl[1:0] == 2'b10) hit = (if_addr >= m_ia1) && (if_addr < m_ia2);
      else                           hit = (if_addr < m_ia1) || (if_addr >= m_ia2);
      e[0] = if_valid && hit && ok0 && ok1;
      e[1] = e[0];
    end
    e[2] = ds_valid && ds_addr == m_da1 && ok2;
    e[3] = ds_valid && ds_addr == m_da2 && ok3;
    return e;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_ia1;
      3'd2: return m_ia2;
      3'd3: return m_da1;
      3'd4: return m_da2;
      3'd5: return {28'b0, m_st};
      default: return '0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] e;
      logic [31:0] r;
      e = exp_ev();
      r = exp_rd(cfg_raddr);
      vecs++;
      if (ev_o !== e) begin
        fails++;
        $display("FAIL %s ev_o actual=%b expected=%b t=%0t", cur_req, ev_o, e, $time);
      end
      if (sticky_o !== m_st) begin
        fails++;
        $display("FAIL %s sticky_o actual=%b expected=%b t=%0t", cur_req, sticky_o, m_st, $time);
      end
      if (cfg_rdata !== r) begin
        fails++;
        $display("FAIL %s rdata[%0d] actual=%h expected=%h t=%0t", cur_req, cfg_raddr, cfg_rdata, r, $time);
      end
      n_ctrl = m_ctrl; n_ia1 = m_ia1; n_ia2 = m_ia2; n_da1 = m_da1; n_da2 = m_da2;
      n_st = m_st | e;
      if (cfg_wr_en && cfg_sup) begin
        case (cfg_addr)
          3'd0: n_ctrl = cfg_wdata & 32'h0003_FFFF;
          3'd1: n_ia1 = cfg_wdata;
          3'd2: n_ia2 = cfg_wdata;
          3'd3: n_da1 = cfg_wdata;
          3'd4: n_da2 = cfg_wdata;
          3'd5: n_st = (m_st & ~cfg_wdata[3:0]) | e;
          default: ;
        endcase
      end
      if (!rst_n) begin
        n_ctrl = '0; n_ia1 = '0; n_ia2 = '0; n_da1 = '0; n_da2 = '0; n_st = '0;
      end
    end
  end

  always @(posedge clk) begin
    m_ctrl <= n_ctrl; m_ia1 <= n_ia1; m_ia2 <= n_ia2;
    m_da1 <= n_da1; m_da2 <= n_da2; m_st <= n_st;
  end

  always @(posedge clk) begin
    #1;
    cfg_raddr = cfg_raddr + 3'd1;
  end

  task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                      input logic su, input logic iv, input logic [31:0] ia,
                      input logic dv, input logic [31:0] da,
                      input logic pr, input logic is, input logic dsp);
    @(posedge clk); #1;
    cfg_wr_en = we; cfg_addr = wa; cfg_wdata = wd; cfg_sup = su;
    if_valid = iv; if_addr = ia; ds_valid = dv; ds_addr = da;
    priv_user = pr; ispace = is; dspace = dsp;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic su);
    step(1'b1, a, d, su, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic fetch(input logic iv, input logic [31:0] a, input logic pr, input logic is);
    step(1'b0, 3'd0, '0, 1'b0, iv, a, 1'b0, '0, pr, is, 1'b0);
  endtask

  task automatic dacc(input logic [31:0] a, input logic pr, input logic dsp);
    step(1'b0, 3'd0, '0, 1'b0, 1'b0, '0, 1'b1, a, pr, 1'b0, dsp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      step(1'b0, 3'd0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(10);

    cur_req = "R12";
    wr(3'd0, 32'hFFFF_FFFF, 1'b0);
    wr(3'd1, 32'h1234_5678, 1'b0);
    idle(8);
    wr(3'd0, 32'hFFFF_FFFF, 1'b1);
    idle(8);
    wr(3'd0, 32'h0, 1'b1);

    cur_req = "R2";
    wr(3'd1, 32'h1000, 1'b1);
    wr(3'd2, 32'h2000, 1'b1);
    fetch(1'b1, 32'h1000, 1'b0, 1'b0);
    fetch(1'b1, 32'h2000, 1'b0, 1'b0);
    fetch(1'b1, 32'h1004, 1'b1, 1'b1);
    cur_req = "R10";
    fetch(1'b0, 32'h1000, 1'b0, 1'b0);
    fetch(1'b0, 32'h2000, 1'b0, 1'b0);

    cur_req = "R3";
    wr(3'd0, 32'h1, 1'b1);
    wr(3'd1, 32'h0000_1200, 1'b1);
    wr(3'd2, 32'hFFFF_FF00, 1'b1);
    fetch(1'b1, 32'h1234, 1'b0, 1'b0);
    fetch(1'b1, 32'h1334, 1'b0, 1'b0);
    fetch(1'b1, 32'h0000_12FF, 1'b1, 1'b0);

    cur_req = "R4";
    wr(3'd0, 32'h2, 1'b1);
    wr(3'd1, 32'h100, 1'b1);
    wr(3'd2, 32'h200, 1'b1);
    fetch(1'b1, 32'hFF, 1'b0, 1'b0);
    fetch(1'b1, 32'h100, 1'b0, 1'b0);
    fetch(1'b1, 32'h1FF, 1'b0, 1'b0);
    fetch(1'b1, 32'h200, 1'b0, 1'b0);
    fetch(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);

    cur_req = "R5";
    wr(3'd0, 32'h3, 1'b1);
    fetch(1'b1, 32'hFF, 1'b0, 1'b0);
    fetch(1'b1, 32'h100, 1'b0, 1'b0);
    fetch(1'b1, 32'h1FF, 1'b0, 1'b0);
    fetch(1'b1, 32'h200, 1'b0, 1'b0);
    fetch(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    fetch(1'b1, 32'h0, 1'b0, 1'b0);

    cur_req = "R7";
    wr(3'd0, 32'h8, 1'b1);
    fetch(1'b1, 32'h100, 1'b0, 1'b0);
    fetch(1'b1, 32'h100, 1'b1, 1'b0);
    wr(3'd0, 32'hC, 1'b1);
    fetch(1'b1, 32'h100, 1'b1, 1'b0);
    fetch(1'b1, 32'h100, 1'b0, 1'b0);

    cur_req = "R8";
    wr(3'd0, 32'h30, 1'b1);
    fetch(1'b1, 32'h100, 1'b0, 1'b1);
    fetch(1'b1, 32'h100, 1'b0, 1'b0);
    wr(3'd3, 32'h5000, 1'b1);
    wr(3'd0, 32'h2000, 1'b1);
    dacc(32'h5000, 1'b0, 1'b0);
    dacc(32'h5000, 1'b0, 1'b1);

    cur_req = "R9";
    wr(3'd0, 32'h400, 1'b1);
    dacc(32'h5000, 1'b0, 1'b0);
    dacc(32'h5000, 1'b1, 1'b1);
    wr(3'd0, 32'h100, 1'b1);
    wr(3'd2, 32'h100, 1'b1);
    fetch(1'b1, 32'h100, 1'b0, 1'b0);
    fetch(1'b1, 32'h100, 1'b1, 1'b1);

    cur_req = "R6";
    wr(3'd2, 32'h200, 1'b1);
    wr(3'd0, 32'hA, 1'b1);
    fetch(1'b1, 32'h180, 1'b0, 1'b0);
    fetch(1'b1, 32'h180, 1'b1, 1'b0);
    wr(3'd0, 32'h2 | 32'h80, 1'b1);
    fetch(1'b1, 32'h180, 1'b1, 1'b0);
    fetch(1'b1, 32'h180, 1'b0, 1'b0);

    cur_req = "R13";
    wr(3'd0, 32'h0, 1'b1);
    wr(3'd4, 32'h7777, 1'b1);
    dacc(32'h7777, 1'b0, 1'b0);
    dacc(32'h7778, 1'b0, 1'b0);
    wr(3'd0, 32'hC000, 1'b1);
    dacc(32'h7777, 1'b0, 1'b0);
    dacc(32'h7777, 1'b1, 1'b0);

    cur_req = "R11";
    idle(8);
    wr(3'd5, 32'h0, 1'b0);
    wr(3'd5, 32'hF, 1'b0);
    idle(8);
    wr(3'd5, 32'h5, 1'b1);
    idle(8);
    wr(3'd0, 32'h0, 1'b1);
    wr(3'd1, 32'h4000, 1'b1);
    fetch(1'b1, 32'h4000, 1'b0, 1'b0);
    step(1'b1, 3'd5, 32'hF, 1'b1, 1'b1, 32'h4000, 1'b0, '0, 1'b0, 1'b0, 1'b0);
    idle(8);
    wr(3'd5, 32'hF, 1'b1);
    idle(8);

    cur_req = "R10";
    wr(3'd3, 32'h40, 1'b1);
    wr(3'd4, 32'h44, 1'b1);
    for (int i = 0; i < 400; i++) begin
      if ((i % 50) == 0) begin
        step(1'b1, 3'd0, $urandom & 32'h0003_FFFF, 1'b1,
             1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 3'd2, 32'h60 + ($urandom & 32'h3F), 1'b1,
             1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
      end else if ((i % 37) == 0) begin
        wr(3'd5, $urandom & 32'hF, 1'b1);
      end else begin
        step(1'b0, 3'd0, '0, 1'b0,
             1'($urandom), $urandom & 32'hFF, 1'($urandom), 32'h40 + ($urandom & 32'h7),
             1'($urandom), 1'($urandom), 1'($urandom));
      end
    end
    idle(4);
    finish_run();
  end
endmodule